// File: doc/BRIEF.md
# Multi-Convention Host Bus Register Bridge

This block connects an external 8-bit processor bus to an internal register file that uses a 15-bit address. The same set of bus pins is read in one of three ways, chosen by a static mode input.

- **Split-strobe mode:** the host uses separate active-low read and write strobes.
- **Direction-strobe mode:** the host uses a read/write direction pin together with one data strobe.
- **Clocked mode:** the host presents everything against a bus clock. The address is captured first, and a later enable or strobe completes the access.

Every bus input passes through a synchronizer into the block's own clock domain, and all decisions are made there. The block issues single-cycle register read and write requests toward the register file. For reads it takes the returned data one cycle after the request, then drives it onto the output side of a split tri-state data bus. It signals completion on a ready output, which stays asserted until the host releases chip select.

Top module: `host_bus_bridge`

## Requirements
- R1: While reset is asserted and just after it is released, `doe`, `rdy`, `reg_wr` and `reg_rd` are low and `dout` is zero.
- R2: With `mode` = 0 (split strobes), an access with `cs_n` low and `wr_n` pulsed low commits `din` to `addr` on the rising edge of `wr_n`.
- R3: With `mode` = 0, a falling edge of `rd_n` with `cs_n` low reads the addressed register. The value is then presented on `dout` with `doe` high.
- R4: With `mode` = 1 (direction strobe), `wr_n` is sampled at the falling edge of `rd_n`. A high level gives a read and a low level gives a write of `din`.
- R5: With `mode` = 2 (clocked), a rising edge of `bus_clk` that sees `cs_n` low captures `addr` and the direction (`wr_n` low = read, high = write). Later changes of `addr` within that access have no effect.
- R6: In clocked mode, an armed read completes at a later `bus_clk` rising edge that sees `dben_n` low. The register contents then appear on `dout`.
- R7: In clocked mode, an armed write completes at a later `bus_clk` rising edge that sees `rd_n` low. The `din` sampled on that edge is written.
- R8: `doe` is high only in the data phase of a read with chip select active. It is never high while a write request is issued, during a write access, or when idle. It goes low the cycle after the synchronized chip select reads high.
- R9: `rdy` rises one clock after a read's data phase begins (`doe` high) or one clock after the `reg_wr` pulse. It falls the cycle after the synchronized chip select reads high.
- R10: Each write access produces exactly one single-cycle `reg_wr` pulse, and each read access produces exactly one single-cycle `reg_rd` pulse.
- R11: Strobe activity while `cs_n` is high issues no request and raises neither `rdy` nor `doe`, and the addressed register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Bus convention: 0 split strobes, 1 direction strobe, 2 clocked, 3 disabled |
| bus_clk | input | 1 | Host bus clock, used only in clocked mode |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe (mode 0) or direction pin (modes 1, 2) |
| rd_n | input | 1 | Read strobe (mode 0), data strobe (mode 1) or write enable (mode 2) |
| dben_n | input | 1 | Data bus enable for clocked-mode reads, active low |
| addr | input | 15 | Host address |
| din | input | 8 | Data bus, input side |
| dout | output | 8 | Data bus, output side |
| doe | output | 1 | Data bus output enable |
| rdy | output | 1 | Ready / acknowledge |
| reg_wr | output | 1 | Register write request, one cycle |
| reg_rd | output | 1 | Register read request, one cycle |
| reg_addr | output | 15 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one cycle after `reg_rd` |

## Verification
The assertions check on every cycle that requests are single-cycle and are only issued after a selected cycle. They also check that the output enable never overlaps a write request, and that both the output enable and ready fall once the synchronized chip select is high. In addition, every rise of ready must trace back to a write pulse or a read data phase. Whether the right address and data reach the register file under each of the three conventions can only be shown by the bench's scenarios. The same holds for the armed address surviving later bus changes in clocked mode and for deselected strobes leaving a register untouched.

// File: rtl/hb_pkg.sv
// Shared types and constants for the host bus bridge.
// Assumes the control bundle layout below is used by every submodule.
package hb_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT   = 2'd0,
        MODE_DIRSTB  = 2'd1,
        MODE_CLOCKED = 2'd2,
        MODE_OFF     = 2'd3
    } bus_mode_t;

    // Bit positions inside the synchronized control bundle
    localparam int CB_BCLK = 4;
    localparam int CB_CS   = 3;
    localparam int CB_WR   = 2;
    localparam int CB_RD   = 1;
    localparam int CB_DBEN = 0;
    localparam int CTRL_W  = 5;
    // Quiet bus: clock low, all active-low pins high
    localparam logic [CTRL_W-1:0] CTRL_QUIET = 5'b01111;

    typedef struct packed {
        logic cs_idle;  // synchronized chip select is high
        logic rd_now;   // async read starts this cycle
        logic wr_now;   // async write commits this cycle
        logic arm_rd;   // clocked read armed
        logic arm_wr;   // clocked write armed
        logic go_rd;    // clocked read completion edge
        logic go_wr;    // clocked write completion edge
        logic release_; // async read strobe released
    } bus_ev_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARM_RD, ST_ARM_WR, ST_RD_FETCH,
        ST_RD_LOAD, ST_RD_HOLD, ST_RD_ACK, ST_WR_ACK
    } hb_state_t;

endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchronizer for a bundle of bits.
// Assumes bits that must be read together stay stable for several clocks.
module hb_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first stage samples the raw bus
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // later stages settle the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hb_decode.sv
// Turns synchronized bus control levels into access events per convention.
// Assumes mode is static while chip select is active.
module hb_decode
    import hb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [CTRL_W-1:0] now,
    output bus_ev_t           ev
);

    logic [CTRL_W-1:0] prev;
    logic              cs_act;
    logic              stb_fall;
    logic              bclk_rise;

    // keep last cycle's levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= CTRL_QUIET;
        else        prev <= now;
    end

    // derive events for the selected convention
    always_comb begin
        cs_act    = ~now[CB_CS];
        stb_fall  = prev[CB_RD] & ~now[CB_RD];
        bclk_rise = ~prev[CB_BCLK] & now[CB_BCLK];
        ev        = '0;
        ev.cs_idle = now[CB_CS];
        case (bus_mode_t'(mode))
            MODE_SPLIT: begin
                ev.rd_now   = cs_act & stb_fall;
                ev.wr_now   = cs_act & ~prev[CB_WR] & now[CB_WR];
                ev.release_ = now[CB_RD];
            end
            MODE_DIRSTB: begin
                ev.rd_now   = cs_act & stb_fall & now[CB_WR];
                ev.wr_now   = cs_act & stb_fall & ~now[CB_WR];
                ev.release_ = now[CB_RD];
            end
            MODE_CLOCKED: begin
                ev.arm_rd = cs_act & bclk_rise & ~now[CB_WR];
                ev.arm_wr = cs_act & bclk_rise &  now[CB_WR];
                ev.go_rd  = cs_act & bclk_rise & ~now[CB_DBEN];
                ev.go_wr  = cs_act & bclk_rise & ~now[CB_RD];
            end
            default: ev.cs_idle = now[CB_CS];
        endcase
    end

endmodule

// File: rtl/hb_ctrl.sv
// Access sequencer: issues register requests, owns the data bus and ready.
// Assumes register read data is valid one clock after the read request.
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_ev_t       ev,
    input  logic [AW-1:0] a_now,
    input  logic [DW-1:0] d_now,
    input  logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic [DW-1:0] dout,
    output logic          doe,
    output logic          rdy
);

    hb_state_t     state;
    logic          ack_state;

    assign ack_state = (state == ST_IDLE) || (state == ST_RD_ACK) || (state == ST_WR_ACK);

    // sequence each access and hold its address, data and requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            dout      <= '0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (ev.cs_idle) begin
                state <= ST_IDLE;
            end else if (ack_state && ev.rd_now) begin
                reg_addr <= a_now;
                reg_rd   <= 1'b1;
                state    <= ST_RD_FETCH;
            end else if (ack_state && ev.wr_now) begin
                reg_addr  <= a_now;
                reg_wdata <= d_now;
                reg_wr    <= 1'b1;
                state     <= ST_WR_ACK;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (ev.arm_rd) begin
                            reg_addr <= a_now;
                            state    <= ST_ARM_RD;
                        end else if (ev.arm_wr) begin
                            reg_addr <= a_now;
                            state    <= ST_ARM_WR;
                        end
                    end
                    ST_ARM_RD: begin
                        if (ev.go_rd) begin
                            reg_rd <= 1'b1;
                            state  <= ST_RD_FETCH;
                        end
                    end
                    ST_ARM_WR: begin
                        if (ev.go_wr) begin
                            reg_wdata <= d_now;
                            reg_wr    <= 1'b1;
                            state     <= ST_WR_ACK;
                        end
                    end
                    ST_RD_FETCH: state <= ST_RD_LOAD;
                    ST_RD_LOAD: begin
                        dout  <= reg_rdata;
                        state <= ST_RD_HOLD;
                    end
                    ST_RD_HOLD: state <= ev.release_ ? ST_IDLE : ST_RD_ACK;
                    ST_RD_ACK:  if (ev.release_) state <= ST_IDLE;
                    default:    state <= state;
                endcase
            end
        end
    end

    // write acknowledge waits one clock behind the request pulse
    logic wr_ack_q;
    always_ff @(posedge clk) begin
        if (!rst_n || ev.cs_idle) wr_ack_q <= 1'b0;
        else if (reg_wr)          wr_ack_q <= 1'b1;
        else if (state != ST_WR_ACK) wr_ack_q <= 1'b0;
    end

    // drive bus enable in the read data phase, ready in acknowledge
    always_comb begin
        doe = (state == ST_RD_HOLD) || (state == ST_RD_ACK);
        rdy = (state == ST_RD_ACK) || ((state == ST_WR_ACK) && wr_ack_q);
    end

endmodule

// File: rtl/host_bus_bridge.sv
// Top of the host bus bridge: synchronizes the bus, decodes events,
// sequences register accesses. Assumes mode changes only while deselected.
module host_bus_bridge
    import hb_pkg::*;
#(
    parameter int AW          = 15,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          bus_clk,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          dben_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          doe,
    output logic          rdy,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);

    localparam int BW = AW + DW;

    logic [CTRL_W-1:0] ctrl_s;
    logic [BW-1:0]     bus_s;
    bus_ev_t           bus_ev;
    logic              cs_idle_s;

    hb_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST(CTRL_QUIET)) u_ctrl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_clk, cs_n, wr_n, rd_n, dben_n}),
        .q     (ctrl_s)
    );

    hb_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST('0)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, din}),
        .q     (bus_s)
    );

    hb_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .now   (ctrl_s),
        .ev    (bus_ev)
    );

    assign cs_idle_s = bus_ev.cs_idle;

    hb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (bus_ev),
        .a_now     (bus_s[BW-1:DW]),
        .d_now     (bus_s[DW-1:0]),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .dout      (dout),
        .doe       (doe),
        .rdy       (rdy)
    );

endmodule

// File: rtl/hb_chk.sv
// Protocol checker for the host bus bridge, attached by bind.
// Assumes cs_idle is the synchronized chip-select-high level.
module hb_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_idle,
    input logic doe,
    input logic rdy,
    input logic reg_wr,
    input logic reg_rd
);

    // R8
    doe_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !doe);

    // R8
    doe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !doe);

    // R9
    rdy_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !rdy);

    // R9
    rdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ($past(reg_wr) || $past(doe)));

    // R10
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R11
    req_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> !$past(cs_idle));

endmodule

bind host_bus_bridge hb_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_idle (cs_idle_s),
    .doe     (doe),
    .rdy     (rdy),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd)
);

// File: tb/tb_host_bus_bridge.sv
module tb_host_bus_bridge;

    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          bus_clk = 1'b0;
    logic          cs_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          dben_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          doe;
    logic          rdy;
    logic          reg_wr;
    logic          reg_rd;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] rdata_q = '0;

    always #10 clk = ~clk;
    always #80 bus_clk = ~bus_clk;

    host_bus_bridge dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .bus_clk(bus_clk),
        .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .dben_n(dben_n),
        .addr(addr), .din(din), .dout(dout), .doe(doe), .rdy(rdy),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_q)
    );

    // register file stub
    logic [7:0] mem [logic [AW-1:0]];
    logic [7:0] shadow [logic [AW-1:0]];

    function automatic logic [7:0] seed_val(logic [AW-1:0] a);
        return a[7:0] ^ 8'h5C;
    endfunction

    always @(posedge clk) begin
        if (reg_wr) mem[reg_addr] = reg_wdata;
        if (reg_rd) rdata_q <= mem.exists(reg_addr) ? mem[reg_addr] : seed_val(reg_addr);
    end

    function automatic logic [7:0] exp_rd(logic [AW-1:0] a);
        return shadow.exists(a) ? shadow[a] : seed_val(a);
    endfunction

    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0, rd_cnt = 0, exp_wr = 0, exp_rdn = 0;
    int doe_in_wr = 0;
    bit in_wr = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit            rd;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         req;
    } item_t;
    item_t sbq[$];

    // monitor: record requests, compare on each new ready
    logic [AW-1:0] last_wa = '0;
    logic [DW-1:0] last_wd = '0;
    logic          rdy_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                wr_cnt++;
                last_wa = reg_addr;
                last_wd = reg_wdata;
            end
            if (reg_rd) rd_cnt++;
            if (doe && in_wr) doe_in_wr++;
            if (rdy && !rdy_prev) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R9", "ready with nothing pending", 1, 0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    if (it.rd)
                        chk(doe && dout == it.d, it.req, "read data",
                            {23'd0, doe, dout}, {23'd0, 1'b1, it.d});
                    else
                        chk(last_wa == it.a && last_wd == it.d, it.req, "write commit",
                            {9'd0, last_wa, last_wd}, {9'd0, it.a, it.d});
                end
            end
            rdy_prev = rdy;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic split_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        sbq.push_back('{0, a, d, req});
        shadow[a] = d; exp_wr++; in_wr = 1;
        @(negedge clk); addr = a; din = d; cs_n = 0;
        wait_clk(3); wr_n = 0;
        wait_clk(4); wr_n = 1;
        wait_clk(6);
        chk(rdy == 1'b1, "R9", "ready after write", rdy, 1);
        cs_n = 1;
        wait_clk(5);
        chk(rdy == 1'b0, "R9", "ready after deselect", rdy, 0);
        in_wr = 0;
    endtask

    task automatic split_read(input logic [AW-1:0] a, input string req);
        sbq.push_back('{1, a, exp_rd(a), req});
        exp_rdn++;
        @(negedge clk); addr = a; cs_n = 0;
        wait_clk(3); rd_n = 0;
        wait_clk(8); rd_n = 1; cs_n = 1;
        wait_clk(5);
        chk(doe == 1'b0, "R8", "bus released after read", doe, 0);
    endtask

    task automatic ds_access(input bit rd, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input string req);
        if (rd) begin
            sbq.push_back('{1, a, exp_rd(a), req}); exp_rdn++;
        end else begin
            sbq.push_back('{0, a, d, req}); shadow[a] = d; exp_wr++; in_wr = 1;
        end
        @(negedge clk); addr = a; din = d; wr_n = rd; cs_n = 0;
        wait_clk(3); rd_n = 0;
        wait_clk(8);
        chk(rdy == 1'b1, "R4", "ready in direction-strobe access", rdy, 1);
        rd_n = 1; cs_n = 1; wr_n = 1;
        wait_clk(5);
        in_wr = 0;
    endtask

    task automatic clk_access(input bit rd, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string req);
        if (rd) begin
            sbq.push_back('{1, a, exp_rd(a), req}); exp_rdn++;
        end else begin
            sbq.push_back('{0, a, d, req}); shadow[a] = d; exp_wr++; in_wr = 1;
        end
        @(negedge bus_clk); cs_n = 0; addr = a; wr_n = !rd; dben_n = 1; rd_n = 1;
        @(negedge bus_clk); addr = ~a; din = d;
        if (rd) dben_n = 0; else rd_n = 0;
        @(negedge bus_clk);
        @(negedge bus_clk); rd_n = 1; dben_n = 1;
        @(negedge clk);
        chk(rdy == 1'b1, rd ? "R6" : "R7", "ready in clocked access", rdy, 1);
        cs_n = 1; wr_n = 1;
        @(negedge bus_clk);
        @(negedge bus_clk);
        in_wr = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        wait_clk(5);
        // R1: outputs quiet in reset
        chk(!doe && !rdy && !reg_wr && !reg_rd && dout == 0, "R1", "reset outputs",
            {doe, rdy, reg_wr, reg_rd, dout}, 0);
        rst_n = 1;
        wait_clk(3);
        chk(!doe && !rdy && !reg_wr && !reg_rd && dout == 0, "R1", "after reset",
            {doe, rdy, reg_wr, reg_rd, dout}, 0);

        mode = 2'd0;
        split_write(15'h1234, 8'hA7, "R2");
        split_write(15'h7FFF, 8'h3C, "R2");
        split_read(15'h1234, "R3");
        split_read(15'h0042, "R3");
        split_read(15'h7FFF, "R3");

        // R11: strobes while deselected
        begin
            int w0, r0;
            w0 = wr_cnt; r0 = rd_cnt;
            @(negedge clk); cs_n = 1; addr = 15'h1234; din = 8'hFF;
            wait_clk(2); wr_n = 0; wait_clk(4); wr_n = 1;
            wait_clk(2); rd_n = 0; wait_clk(6);
            chk(wr_cnt == w0 && rd_cnt == r0, "R11", "no request when deselected",
                wr_cnt + rd_cnt, w0 + r0);
            chk(!rdy && !doe, "R11", "no ready or enable when deselected", {rdy, doe}, 0);
            rd_n = 1; wait_clk(4);
        end
        split_read(15'h1234, "R11");

        mode = 2'd1;
        wait_clk(2);
        ds_access(0, 15'h0100, 8'h55, "R4");
        ds_access(1, 15'h0100, 8'h00, "R4");
        ds_access(1, 15'h2222, 8'h00, "R4");

        mode = 2'd2;
        wait_clk(2);
        clk_access(0, 15'h0BEE, 8'h9D, "R7");
        clk_access(1, 15'h0BEE, 8'h00, "R6");
        clk_access(0, 15'h5000, 8'h11, "R5");
        clk_access(1, 15'h5000, 8'h00, "R5");
        clk_access(1, ~15'h5000, 8'h00, "R5");

        wait_clk(10);
        chk(wr_cnt == exp_wr, "R10", "write pulse count", wr_cnt, exp_wr);
        chk(rd_cnt == exp_rdn, "R10", "read pulse count", rd_cnt, exp_rdn);
        chk(doe_in_wr == 0, "R8", "enable during writes", doe_in_wr, 0);
        chk(sbq.size() == 0, "R9", "accesses without ready", sbq.size(), 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule